// File: doc/BRIEF.md
# Serial Bitwise Magnitude Comparator

This block decides which of two unsigned numbers is larger while the numbers stream in one bit per clock, most significant bit first, on two serial lines. Each bit pair is qualified by a valid strobe. The first position where the two streams differ settles the answer for the rest of the word. Later bits cannot change it, so the block latches that outcome and reports it until a new comparison begins.

Two flags report the result. `a_gt` means the A stream is larger over the bits seen so far, and `b_gt` means the B stream is larger. The flags are Mealy outputs: the deciding bit shows on the flags in the same cycle it is presented. A synchronous `start` pulse opens a new comparison. If `start` arrives together with a valid bit, that bit is the first bit of the new word. Word length is the caller's concern. The block keeps no bit count.

Top module: `serial_mag_cmp`

## Requirements
- R1: While `rst` is high at a rising edge, the comparison returns to the equal state. In the first cycle after reset, with `valid` low and `start` low, both `a_gt` and `b_gt` read 0.
- R2: While the comparison is still equal and `valid` is high, the flags follow the current bit pair in the same cycle. `a_gt` = `a_bit & ~b_bit` and `b_gt` = `b_bit & ~a_bit`.
- R3: `a_gt` and `b_gt` are never 1 at the same time. Both read 0 while every valid bit pair since the last start or reset has been equal.
- R4: Once `a_gt` has read 1, it stays 1 and `b_gt` stays 0 in every later cycle, whatever bits arrive, until the next `start` or reset.
- R5: Once `b_gt` has read 1, it stays 1 and `a_gt` stays 0 in every later cycle, whatever bits arrive, until the next `start` or reset.
- R6: In a cycle with `valid` low, `a_bit` and `b_bit` have no effect on the flags or on the stored outcome. The flags show only the stored outcome.
- R7: A cycle with `start` high discards the previous outcome. If `valid` is also high, that cycle's bit pair is judged as the first bit of the new word, with its effect visible on the flags in that same cycle.
- R8: A cycle with `start` high and `valid` low reads 0 on both flags. The following cycle, with `valid` low and `start` low, also reads 0 on both flags.
- R9: For A = 1,1,0,0,0 and B = 1,0,1,0,0 on successive valid cycles, with `start` on the first, `a_gt` reads 0,1,1,1,1 and `b_gt` reads 0,0,0,0,0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Synchronous active-high begin-new-comparison pulse |
| valid | input | 1 | Qualifies `a_bit` and `b_bit` in this cycle |
| a_bit | input | 1 | Serial bit of operand A, MSB first |
| b_bit | input | 1 | Serial bit of operand B, MSB first |
| a_gt | output | 1 | A is larger over the bits seen so far |
| b_gt | output | 1 | B is larger over the bits seen so far |

## Verification
A wrong stored outcome shows on the flags in the cycle right after the bit that caused it, even with `valid` low. The flags always reflect the stored outcome, so a decision that was lost or flipped is visible one clock later. A failure to latch shows as a flag dropping back to 0 once the deciding bit has gone. A false latch shows as a flag rising on an equal pair or on a non-valid cycle. A broken `start` path shows up as an old outcome that survives into a new word, visible on the very start cycle.

// File: rtl/serial_mag_cmp.sv
module serial_mag_cmp (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic valid,
  input  logic a_bit,
  input  logic b_bit,
  output logic a_gt,
  output logic b_gt
);

  typedef enum logic [1:0] {
    CMP_EQ  = 2'd0,
    CMP_AHI = 2'd1,
    CMP_BHI = 2'd2
  } cmp_t;

  cmp_t cur_q, base, nxt;
  logic a_wins, b_wins;

  assign base   = start ? CMP_EQ : cur_q;
  assign a_wins = valid & a_bit & ~b_bit;
  assign b_wins = valid & b_bit & ~a_bit;

  always_comb begin
    nxt = base;
    if (base == CMP_EQ) begin
      if (a_wins)      nxt = CMP_AHI;
      else if (b_wins) nxt = CMP_BHI;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur_q <= CMP_EQ;
    else     cur_q <= nxt;
  end

  assign a_gt = (base == CMP_AHI) | ((base == CMP_EQ) & a_wins);
  assign b_gt = (base == CMP_BHI) | ((base == CMP_EQ) & b_wins);

endmodule

// File: rtl/serial_mag_cmp_chk.sv
module serial_mag_cmp_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic valid,
  input logic a_bit,
  input logic b_bit,
  input logic a_gt,
  input logic b_gt
);

  p_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(a_gt && b_gt));

  p_equal_pair_r3: assert property (@(posedge clk) disable iff (rst)
    (start && valid && (a_bit == b_bit)) |-> (!a_gt && !b_gt));

  p_a_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    a_gt |=> (start || (a_gt && !b_gt)));

  p_b_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    b_gt |=> (start || (b_gt && !a_gt)));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!valid && !start && $past(!valid && !start && !rst)) |-> ($stable(a_gt) && $stable(b_gt)));

  p_first_bit_r7: assert property (@(posedge clk) disable iff (rst)
    (start && valid) |-> (a_gt == (a_bit && !b_bit)) && (b_gt == (b_bit && !a_bit)));

  p_start_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !valid) |-> (!a_gt && !b_gt));

endmodule

bind serial_mag_cmp serial_mag_cmp_chk chk_i (
  .clk(clk), .rst(rst), .start(start), .valid(valid),
  .a_bit(a_bit), .b_bit(b_bit), .a_gt(a_gt), .b_gt(b_gt)
);

// File: tb/serial_mag_cmp_tb_top.sv
`timescale 1ns/100ps
module serial_mag_cmp_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic valid = 1'b0;
  logic a_bit = 1'b0;
  logic b_bit = 1'b0;
  logic a_gt, b_gt;

  int vectors = 0;
  int miscompares = 0;
  int model = 0;
  logic [1:0] exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_mag_cmp dut_i (
    .clk(clk), .rst(rst), .start(start), .valid(valid),
    .a_bit(a_bit), .b_bit(b_bit), .a_gt(a_gt), .b_gt(b_gt)
  );

  task automatic apply(input bit s, input bit v, input bit a, input bit b, input string tag);
    int base;
    logic [1:0] e;
    @(negedge clk);
    start = s; valid = v; a_bit = a; b_bit = b;
    base = s ? 0 : model;
    if (base == 0 && v && a && !b) model = 1;
    else if (base == 0 && v && b && !a) model = 2;
    else model = base;
    if (base == 1) e = 2'b10;
    else if (base == 2) e = 2'b01;
    else e = {v & a & ~b, v & b & ~a};
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0; valid = 1'b0;
    model = 0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      while (exp_q.size() > 0 && tag_q.size() > 0) begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        vectors++;
        if ({a_gt, b_gt} !== e) begin
          miscompares++;
          $display("FAIL %s: {a_gt,b_gt} actual=%b expected=%b", t, {a_gt, b_gt}, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst = 1'b0;
    apply(0, 0, 1, 0, "R1 idle after reset");
    apply(0, 0, 0, 1, "R6 idle in equal ignores bits");
    // R9 worked example
    apply(1, 1, 1, 1, "R9 bit4");
    apply(0, 1, 1, 0, "R9 bit3");
    apply(0, 1, 0, 1, "R9 bit2 R4");
    apply(0, 1, 0, 0, "R9 bit1");
    apply(0, 1, 0, 0, "R9 bit0");
    apply(0, 0, 0, 1, "R6 idle holds A>B");
    apply(0, 1, 0, 1, "R4 late B bit ignored");
    // R7 start with valid, B decides at once
    apply(1, 1, 0, 1, "R7 start+valid first bit");
    apply(0, 1, 1, 0, "R5 late A bit ignored");
    apply(0, 0, 1, 0, "R6 idle holds B>A");
    apply(0, 1, 1, 1, "R5 equal bit keeps B");
    // R8 start without valid
    apply(1, 0, 1, 0, "R8 start without valid");
    apply(0, 0, 1, 0, "R8 after start idle");
    // R2/R3 equal pairs then decision
    apply(0, 1, 1, 1, "R3 equal 1,1");
    apply(0, 1, 0, 0, "R3 equal 0,0");
    apply(0, 1, 1, 0, "R2 first difference A");
    apply(1, 1, 0, 0, "R7 restart equal bit");
    apply(0, 1, 0, 1, "R2 first difference B");
    apply(0, 1, 1, 0, "R5 stays B");
    do_reset();
    apply(0, 0, 0, 0, "R1 mid-run reset clears");
    apply(0, 1, 1, 0, "R2 after reset A");
    apply(0, 0, 0, 0, "R4 hold after reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule